// File: doc/BRIEF.md
# Nanosecond Real-Time Clock with Alarm

This peripheral keeps a free-running 64-bit count of nanoseconds that advances by a fixed step, `NS_PER_CLK`, on every clock cycle. Software reaches it through a 32-bit register port with an address, a write strobe, a read strobe, write data and registered read data. The count is split into two 32-bit halves. Each half can be read and each can be overwritten on its own. A read of the lower half also captures the upper half into a holding register, so a later read of the upper half returns a value that matches the lower half already read.

A 64-bit alarm value is compared against the count. Only a write to the alarm's lower half arms it. The upper half is simply stored, so software writes the upper half first. When the armed alarm is at or below the count, the alarm disarms itself and sets a pending flag. This also happens when the alarm is already in the past at the moment it is armed. The interrupt output is the pending flag gated by a one-bit enable.

Register offsets (byte addresses, 32-bit accesses only): 0x00 count low, 0x04 count high, 0x08 alarm low, 0x0C alarm high, 0x10 interrupt enable, 0x14 disarm alarm, 0x18 alarm armed status, 0x1C clear pending.

Top module: `ns_rtc`

## Requirements
- R1: After reset, the count reads 0. The alarm halves, alarm status and interrupt enable all read 0, and `irq` is 0.
- R2: Without a count write, the count grows by `NS_PER_CLK` every cycle. A carry out of bit 31 reaches bit 32. A read at 0x00 returns bits 31:0 of the count as held at the clock edge that takes the read strobe.
- R3: A read at 0x00 copies count bits 63:32 into a holding register. A read at 0x04 returns that holding register and not the live upper half.
- R4: A write at 0x00 replaces only count bits 31:0, and a write at 0x04 replaces only bits 63:32. In the cycle of such a write the step is not added, and counting resumes from the written value.
- R5: A write at 0x0C stores alarm bits 63:32 and does not arm the alarm. A read at 0x08 or 0x0C returns the stored alarm half.
- R6: A write at 0x08 stores alarm bits 31:0 and arms the alarm, so a read at 0x18 returns 1. On the edge that sees an armed alarm at or below the count, the alarm disarms and the pending flag sets.
- R7: If the new alarm value is already at or below the count when 0x08 is written, the pending flag sets on that same edge and the alarm does not stay armed.
- R8: `irq` is the pending flag AND the enable bit. A write at 0x10 keeps only data bit 0, and a read at 0x10 returns it.
- R9: A write at 0x1C clears the pending flag. A write at 0x14 disarms the alarm and leaves the pending flag unchanged. A disarmed alarm never fires.
- R10: Offsets 0x14, 0x1C and 0x20 read as 0. Writes at 0x18 and 0x20 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Byte offset of the access |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt |

## Verification
Every result is due one clock edge after its stimulus. Read data appears after the edge that takes the read strobe. A write to the count, alarm, enable or clear registers takes effect on its own edge. The pending flag sets on the edge whose sampled count first reaches the armed alarm. The bench drives each access on a falling edge and samples `rdata` and `irq` on the next falling edge. It counts edges from a known count write, so the expected count values and the exact edge of the alarm hit follow from the step size alone. In the timed alarm test, `irq` is checked low one cycle before the predicted edge and high right after it.

// File: rtl/ns_rtc_pkg.sv
// Shared constants and types for the nanosecond RTC.
// Assumes a 32-bit register port and a 64-bit count made of whole words.
package ns_rtc_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned CNT_W  = 64;
    localparam int unsigned HALVES = CNT_W / WORD_W;

    // Byte offsets of the register window.
    localparam logic [7:0] OFF_CNT_LO   = 8'h00;
    localparam logic [7:0] OFF_CNT_HI   = 8'h04;
    localparam logic [7:0] OFF_ALM_LO   = 8'h08;
    localparam logic [7:0] OFF_ALM_HI   = 8'h0C;
    localparam logic [7:0] OFF_IRQ_EN   = 8'h10;
    localparam logic [7:0] OFF_ALM_OFF  = 8'h14;
    localparam logic [7:0] OFF_ALM_STAT = 8'h18;
    localparam logic [7:0] OFF_PEND_CLR = 8'h1C;

    // Which register a read selects.
    typedef enum logic [2:0] {
        RS_NONE,
        RS_CNT_LO,
        RS_CNT_HI,
        RS_ALM_LO,
        RS_ALM_HI,
        RS_IRQ_EN,
        RS_ALM_STAT
    } rd_sel_e;

    // One-hot strobes for the write side.
    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic alm_lo;
        logic alm_hi;
        logic irq_en;
        logic alm_off;
        logic pend_clr;
    } wr_sel_t;

endpackage

// File: rtl/ns_rtc_decode.sv
// Address decoder: turns an access into write strobes and a read select.
// Assumes ADDR_W >= 6 and word-aligned offsets. Unknown offsets select nothing.
module ns_rtc_decode
    import ns_rtc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output wr_sel_t           wsel,
    output rd_sel_e           rsel
);

    localparam logic [ADDR_W-1:0] A_CNT_LO   = ADDR_W'(OFF_CNT_LO);
    localparam logic [ADDR_W-1:0] A_CNT_HI   = ADDR_W'(OFF_CNT_HI);
    localparam logic [ADDR_W-1:0] A_ALM_LO   = ADDR_W'(OFF_ALM_LO);
    localparam logic [ADDR_W-1:0] A_ALM_HI   = ADDR_W'(OFF_ALM_HI);
    localparam logic [ADDR_W-1:0] A_IRQ_EN   = ADDR_W'(OFF_IRQ_EN);
    localparam logic [ADDR_W-1:0] A_ALM_OFF  = ADDR_W'(OFF_ALM_OFF);
    localparam logic [ADDR_W-1:0] A_ALM_STAT = ADDR_W'(OFF_ALM_STAT);
    localparam logic [ADDR_W-1:0] A_PEND_CLR = ADDR_W'(OFF_PEND_CLR);

    // Write strobes: one per writable offset. The status offset has none (R10).
    always_comb begin
        wsel.cnt_lo   = wr_en && (addr == A_CNT_LO);
        wsel.cnt_hi   = wr_en && (addr == A_CNT_HI);
        wsel.alm_lo   = wr_en && (addr == A_ALM_LO);
        wsel.alm_hi   = wr_en && (addr == A_ALM_HI);
        wsel.irq_en   = wr_en && (addr == A_IRQ_EN);
        wsel.alm_off  = wr_en && (addr == A_ALM_OFF);
        wsel.pend_clr = wr_en && (addr == A_PEND_CLR);
    end

    // Read select: write-only and unknown offsets map to RS_NONE, which reads 0.
    always_comb begin
        rsel = RS_NONE;
        if (rd_en) begin
            if      (addr == A_CNT_LO)   rsel = RS_CNT_LO;
            else if (addr == A_CNT_HI)   rsel = RS_CNT_HI;
            else if (addr == A_ALM_LO)   rsel = RS_ALM_LO;
            else if (addr == A_ALM_HI)   rsel = RS_ALM_HI;
            else if (addr == A_IRQ_EN)   rsel = RS_IRQ_EN;
            else if (addr == A_ALM_STAT) rsel = RS_ALM_STAT;
        end
    end

endmodule

// File: rtl/ns_rtc_counter.sv
// Nanosecond counter: adds STEP each cycle, or loads one word-wide half.
// Assumes at most one half is written per cycle. A write replaces that
// cycle's increment (R4).
module ns_rtc_counter
    import ns_rtc_pkg::*;
#(
    parameter int unsigned STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALVES-1:0] wr_half,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_nxt;

    // Next count: hold on a write, otherwise step. Then overlay the written half.
    always_comb begin
        count_nxt = (|wr_half) ? count_q : count_q + CNT_W'(STEP);
        for (int h = 0; h < int'(HALVES); h++) begin
            if (wr_half[h]) count_nxt[h*WORD_W +: WORD_W] = wdata;
        end
    end

    // Count register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_nxt;
    end

    assign count = count_q;

endmodule

// File: rtl/ns_rtc_alarm.sv
// Alarm comparator, pending flag and interrupt enable.
// Assumes one write strobe per cycle. A hit on the same edge as a pending
// clear wins, so an event is never lost.
module ns_rtc_alarm
    import ns_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count,
    input  wr_sel_t           wsel,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  alarm,
    output logic              running,
    output logic              pending,
    output logic              irq_en
);

    logic [CNT_W-1:0] alarm_q, alarm_nxt;
    logic             run_q, pend_q, en_q;
    logic             live_hit, arm_past;

    // Alarm value after this cycle's writes. The two halves are stored independently.
    always_comb begin
        alarm_nxt = alarm_q;
        if (wsel.alm_lo) alarm_nxt[WORD_W-1:0]     = wdata;
        if (wsel.alm_hi) alarm_nxt[CNT_W-1:WORD_W] = wdata;
    end

    // Hit conditions: the armed alarm is reached, or a new alarm is armed already in the past.
    assign live_hit = run_q && (alarm_q <= count);
    assign arm_past = wsel.alm_lo && (alarm_nxt <= count);

    // Alarm, armed, pending and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
            run_q   <= 1'b0;
            pend_q  <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            alarm_q <= alarm_nxt;
            if (wsel.alm_lo)                  run_q <= !arm_past;
            else if (wsel.alm_off || live_hit) run_q <= 1'b0;
            if (live_hit || arm_past)          pend_q <= 1'b1;
            else if (wsel.pend_clr)           pend_q <= 1'b0;
            if (wsel.irq_en)                  en_q <= wdata[0];
        end
    end

    assign alarm   = alarm_q;
    assign running = run_q;
    assign pending = pend_q;
    assign irq_en  = en_q;

endmodule

// File: rtl/ns_rtc_rdport.sv
// Registered read port and the upper-half holding register.
// Assumes the read select is already decoded. Data is valid one cycle after the strobe.
module ns_rtc_rdport
    import ns_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  rd_sel_e           rsel,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  alarm,
    input  logic              running,
    input  logic              irq_en,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] rdata_q;
    logic [WORD_W-1:0] mux;

    // Read multiplexer. Unselected offsets give zero (R10).
    always_comb begin
        unique case (rsel)
            RS_CNT_LO:   mux = count[WORD_W-1:0];
            RS_CNT_HI:   mux = hold_q;
            RS_ALM_LO:   mux = alarm[WORD_W-1:0];
            RS_ALM_HI:   mux = alarm[CNT_W-1:WORD_W];
            RS_IRQ_EN:   mux = WORD_W'(irq_en);
            RS_ALM_STAT: mux = WORD_W'(running);
            default:     mux = '0;
        endcase
    end

    // Read data register, plus capture of the upper half on a low-half read (R3).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            hold_q  <= '0;
        end else begin
            rdata_q <= mux;
            if (rsel == RS_CNT_LO) hold_q <= count[CNT_W-1:WORD_W];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/ns_rtc.sv
// Nanosecond real-time clock with a 64-bit alarm and a maskable level interrupt.
// Assumes 32-bit accesses and at most one write per cycle. The count steps
// NS_PER_CLK every clock.
module ns_rtc
    import ns_rtc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NS_PER_CLK = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);

    wr_sel_t          wsel;
    rd_sel_e          rsel;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] alarm_q;
    logic             alarm_run;
    logic             irq_pend;
    logic             irq_en_q;

    ns_rtc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wsel  (wsel),
        .rsel  (rsel)
    );

    ns_rtc_counter #(.STEP(NS_PER_CLK)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_half ({wsel.cnt_hi, wsel.cnt_lo}),
        .wdata   (wdata),
        .count   (count_q)
    );

    ns_rtc_alarm u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (count_q),
        .wsel    (wsel),
        .wdata   (wdata),
        .alarm   (alarm_q),
        .running (alarm_run),
        .pending (irq_pend),
        .irq_en  (irq_en_q)
    );

    ns_rtc_rdport u_rdport (
        .clk     (clk),
        .rst_n   (rst_n),
        .rsel    (rsel),
        .count   (count_q),
        .alarm   (alarm_q),
        .running (alarm_run),
        .irq_en  (irq_en_q),
        .rdata   (rdata)
    );

    // Interrupt level: the pending flag gated by the enable bit (R8).
    assign irq = irq_pend & irq_en_q;

endmodule

// File: rtl/ns_rtc_chk.sv
// Property checker for ns_rtc, attached by bind. It decodes writes on its own.
module ns_rtc_chk
    import ns_rtc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NS_PER_CLK = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [31:0]       wdata,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  alarm,
    input logic              running,
    input logic              pending,
    input logic              irq_en
);

    logic w_cnt, w_alo, w_ahi, w_en, w_off, w_clr;
    assign w_cnt = wr_en && (addr == ADDR_W'(OFF_CNT_LO) || addr == ADDR_W'(OFF_CNT_HI));
    assign w_alo = wr_en && (addr == ADDR_W'(OFF_ALM_LO));
    assign w_ahi = wr_en && (addr == ADDR_W'(OFF_ALM_HI));
    assign w_en  = wr_en && (addr == ADDR_W'(OFF_IRQ_EN));
    assign w_off = wr_en && (addr == ADDR_W'(OFF_ALM_OFF));
    assign w_clr = wr_en && (addr == ADDR_W'(OFF_PEND_CLR));

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !w_cnt |=> count == $past(count) + CNT_W'(NS_PER_CLK));

    a_r5_hi_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        w_ahi && !running |=> !running);

    a_r6_hit_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        running && alarm <= count |=> pending);

    a_r7_past_fires: assert property (@(posedge clk) disable iff (!rst_n)
        w_alo && {alarm[CNT_W-1:WORD_W], wdata} <= count |=> pending && !running);

    a_r8_disable_masks: assert property (@(posedge clk) disable iff (!rst_n)
        w_en && !wdata[0] |=> !irq);

    a_r9_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        w_off |=> !running);

    a_r9_clear_pending: assert property (@(posedge clk) disable iff (!rst_n)
        w_clr && !(running && alarm <= count) |=> !pending);

endmodule

bind ns_rtc ns_rtc_chk #(.ADDR_W(ADDR_W), .NS_PER_CLK(NS_PER_CLK)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .irq     (irq),
    .count   (count_q),
    .alarm   (alarm_q),
    .running (alarm_run),
    .pending (irq_pend),
    .irq_en  (irq_en_q)
);

// File: tb/ns_rtc_test.sv
`timescale 1ns/1ps
// Self-checking bench for ns_rtc. Each access takes exactly one cycle, so
// expected values are counted in edges.
module ns_rtc_test;

    localparam int unsigned STEP = 8;

    localparam logic [7:0] A_CLO = 8'h00, A_CHI = 8'h04, A_ALO = 8'h08, A_AHI = 8'h0C,
                           A_IEN = 8'h10, A_OFF = 8'h14, A_STA = 8'h18, A_CLR = 8'h1C,
                           A_GAP = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ns_rtc #(.ADDR_W(8), .NS_PER_CLK(STEP)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;     // write data, or the expected read value
        logic [3:0]  req;
    } vec_t;

    // One row per cycle. Count values follow from the write in row 0.
    localparam vec_t VECS [21] = '{
        '{1'b1, 8'h00, 32'h0000_1000, 4'd4},   // R4 load low half
        '{1'b0, 8'h00, 32'h0000_1000, 4'd4},   // R4 value as written
        '{1'b0, 8'h00, 32'h0000_1008, 4'd2},   // R2 one step later
        '{1'b1, 8'h04, 32'h0000_0005, 4'd4},   // R4 upper half write, no step
        '{1'b0, 8'h00, 32'h0000_1010, 4'd4},   // R4 low half unchanged; latches 5
        '{1'b1, 8'h04, 32'h0000_0009, 4'd3},   // R3 live upper half moves to 9
        '{1'b0, 8'h04, 32'h0000_0005, 4'd3},   // R3 holding register, not live
        '{1'b0, 8'h00, 32'h0000_1020, 4'd2},   // R2 latches 9
        '{1'b0, 8'h04, 32'h0000_0009, 4'd3},   // R3
        '{1'b1, 8'h0C, 32'h0000_0007, 4'd5},   // R5 alarm upper half
        '{1'b0, 8'h0C, 32'h0000_0007, 4'd5},   // R5 readback
        '{1'b0, 8'h18, 32'h0000_0000, 4'd5},   // R5 not armed
        '{1'b1, 8'h10, 32'hFFFF_FFFE, 4'd8},   // R8 bit 0 clear
        '{1'b0, 8'h10, 32'h0000_0000, 4'd8},   // R8
        '{1'b1, 8'h10, 32'h0000_0003, 4'd8},   // R8 only bit 0 kept
        '{1'b0, 8'h10, 32'h0000_0001, 4'd8},   // R8
        '{1'b1, 8'h20, 32'hFFFF_FFFF, 4'd10},  // R10 write to gap
        '{1'b0, 8'h20, 32'h0000_0000, 4'd10},  // R10
        '{1'b0, 8'h14, 32'h0000_0000, 4'd10},  // R10
        '{1'b0, 8'h1C, 32'h0000_0000, 4'd10},  // R10
        '{1'b0, 8'h08, 32'h0000_0000, 4'd1}    // R1 alarm low still reset value
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Called at a falling edge. Returns at the next falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(A_CLO, v); check("R1 count", v, 32'h0);
        rd(A_STA, v); check("R1 status", v, 32'h0);
        rd(A_IEN, v); check("R1 enable", v, 32'h0);
        rd(A_ALO, v); check("R1 alarm lo", v, 32'h0);
        rd(A_AHI, v); check("R1 alarm hi", v, 32'h0);

        // Vector table
        for (int i = 0; i < 21; i++) begin
            if (VECS[i].wr) wr(VECS[i].a, VECS[i].d);
            else begin
                rd(VECS[i].a, v);
                check($sformatf("R%0d row%0d", VECS[i].req, i), v, VECS[i].d);
            end
        end

        // R7 alarm {7,0} is below count {9,..}: fires on the arming edge
        wr(A_ALO, 32'h0);
        check("R7 irq at once", {31'b0, irq}, 32'h1);
        rd(A_STA, v); check("R7 not armed", v, 32'h0);
        wr(A_CLR, 32'h0);
        check("R9 pending cleared", {31'b0, irq}, 32'h0);

        // R6 alarm at 200 ns: fires on the 26th edge after the count load
        wr(A_CHI, 32'h0);
        wr(A_CLO, 32'h0);
        wr(A_AHI, 32'h0);
        wr(A_ALO, 32'd200);
        rd(A_STA, v); check("R6 armed", v, 32'h1);
        repeat (22) @(negedge clk);
        check("R6 not early", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R6 fired", {31'b0, irq}, 32'h1);
        rd(A_STA, v); check("R6 disarmed", v, 32'h0);

        // R8 masking keeps pending
        wr(A_IEN, 32'h0);
        check("R8 masked", {31'b0, irq}, 32'h0);
        wr(A_IEN, 32'h1);
        check("R8 unmasked", {31'b0, irq}, 32'h1);

        // R9 disarm leaves pending alone
        wr(A_AHI, 32'h1);
        wr(A_ALO, 32'h0);
        rd(A_STA, v); check("R9 armed", v, 32'h1);
        wr(A_OFF, 32'h0);
        rd(A_STA, v); check("R9 disarmed", v, 32'h0);
        check("R9 pending kept", {31'b0, irq}, 32'h1);
        wr(A_CLR, 32'h0);
        check("R9 cleared", {31'b0, irq}, 32'h0);

        // R10 status offset ignores writes
        wr(A_STA, 32'h1);
        rd(A_STA, v); check("R10 status write", v, 32'h0);

        // R2 carry into the upper half. Passing disarmed alarm {1,0} must not fire (R9).
        wr(A_CHI, 32'h0);
        wr(A_CLO, 32'hFFFF_FFF8);
        rd(A_CLO, v); check("R2 pre-carry", v, 32'hFFFF_FFF8);
        rd(A_CLO, v); check("R2 post-carry lo", v, 32'h0);
        rd(A_CHI, v); check("R2 post-carry hi", v, 32'h1);
        check("R9 no fire when disarmed", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule